// File: doc/BRIEF.md
# Mode-Selectable Analog-Side Pin Controller

This block governs four general-purpose pins from one 8-bit mode register that holds a 2-bit field for each pin. Each pin can be a plain input, an input that wakes the oscillator on a falling edge, an output driven from a level register, or a pass-through that connects the pin to a host serial bus under the control of chip-select. Each pin has its own fixed pass-through function. Pin 1 can feed the serial data output. Pins 2 and 3 can repeat the serial data input and the serial clock. Pin 4 can carry the inverted chip-select.

Software uses a small register port with three locations. Address 0 holds the mode register. Address 1 holds the level register, which reads back the synchronized level of each input pin and the stored level of each driven pin. Address 2 holds the sticky oscillator-enable flag. The pad driver receives an output-enable and an output value for each pin. The block does not do level shifting, pull-ups or serial protocol decoding.

Top module: `apio_ctrl`

## Requirements
- R1: After reset the mode register, the level register and the oscillator flag are all 0. Every pin_oe and pin_out bit is 0.
- R2: Address 0 is the mode register. Pin k (k = 1..4) uses bits [2k-1:2k-2]. The codes are 00 plain input, 01 wake input, 10 output and 11 pass-through. A write to address 0 reads back unchanged at the same address.
- R3: A pin in mode 00 or 01 is not driven (pin_oe = 0, pin_out = 0). Its level reads back at bit k-1 of address 1 once two rising edges have passed after the pin changes.
- R4: A pin in mode 10 is driven (pin_oe = 1) with the value of its bit in the level register (address 1, bit k-1). Reading address 1 returns that stored value, whatever the pin input is.
- R5: For a pin in mode 01, a falling edge on its input sets osc_en on the third rising edge after the fall. A falling edge on a pin in any other mode leaves osc_en at 0.
- R6: osc_en stays set until bit 0 of a write to address 2 clears it. A write of 1 to that bit sets it. Address 2 reads osc_en back in bit 0. When a wake edge and a clearing write arrive in the same cycle, the flag is set.
- R7: When pin 1 is in mode 11, it is not driven and its level reads back as in R3. With ser_cs high, ser_dout follows pin_in[0]. With ser_cs low, ser_dout follows ser_dout_core. In every other case ser_dout follows ser_dout_core.
- R8: When pin 2 is in mode 11, it is driven. Its value is ser_din while ser_cs is high and level bit 1 while ser_cs is low.
- R9: When pin 3 is in mode 11, it is driven. Its value is ser_sclk while ser_cs is high and level bit 2 while ser_cs is low.
- R10: When pin 4 is in mode 11, it is driven with the inverse of ser_cs.
- R11: Moving a pin into mode 01 while its input is already low causes no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 level, 2 oscillator flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 4 | Asynchronous pin input levels |
| pin_oe | output | 4 | Output-enable per pin |
| pin_out | output | 4 | Output value per pin (0 when not driven) |
| ser_cs | input | 1 | Host serial chip-select |
| ser_sclk | input | 1 | Host serial clock |
| ser_din | input | 1 | Host serial data in |
| ser_dout_core | input | 1 | Serial data output from the internal serial logic |
| ser_dout | output | 1 | Serial data output toward the host |
| osc_en | output | 1 | Sticky oscillator-enable flag |

## Verification
The mux is tested with a table of vectors. The table uses uniform mode words (all inputs, all wake, all outputs, all pass-through) and mixed mode words. Chip-select is set both high and low, and serial clock and data are set opposite to the stored levels. This shows whether a pin follows the bus, follows its register bit, or is left undriven. The wake path is tested three ways: a fall in plain-input mode, a mode change into wake mode while the pin is already low, and a real fall in wake mode. Only the real fall may set the flag, and its arrival cycle is checked. One further test makes a clearing write coincide with a detected edge to check that the set wins.

// File: rtl/apio_pkg.sv
package apio_pkg;
  localparam int NUM_PINS  = 4;
  localparam int MODE_W    = 2;
  localparam int REG_W     = NUM_PINS * MODE_W;
  localparam int ADDR_W    = 2;
  localparam int SYNC_STG  = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OSC   = 2'd2;

  typedef enum logic [MODE_W-1:0] {
    MODE_GPIN  = 2'b00,
    MODE_WAKE  = 2'b01,
    MODE_GPOUT = 2'b10,
    MODE_PASS  = 2'b11
  } pin_mode_e;

  // Field of pin idx (0-based) in the mode register
  function automatic pin_mode_e mode_of(input logic [REG_W-1:0] r, input int idx);
    return pin_mode_e'(r[idx*MODE_W +: MODE_W]);
  endfunction

  // Pass-through source for a given pin index: 0 none, 1 din, 2 sclk, 3 ~cs
  function automatic logic pass_value(input int idx, input logic cs,
                                      input logic sclk, input logic din,
                                      input logic lvl);
    logic v;
    case (idx)
      1:       v = cs ? din  : lvl;
      2:       v = cs ? sclk : lvl;
      3:       v = ~cs;
      default: v = 1'b0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/apio_sync_edge.sv
module apio_sync_edge #(
  parameter int STAGES = apio_pkg::SYNC_STG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic arm,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_async};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign fall  = arm & prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/apio_pin_drive.sv
module apio_pin_drive
  import apio_pkg::*;
#(
  parameter int PIN_IDX = 0
) (
  input  pin_mode_e mode,
  input  logic      lvl,
  input  logic      cs,
  input  logic      sclk,
  input  logic      din,
  output logic      oe,
  output logic      out
);
  localparam bit PASS_DRIVES = (PIN_IDX != 0);

  always_comb begin
    oe  = 1'b0;
    out = 1'b0;
    case (mode)
      MODE_GPOUT: begin
        oe  = 1'b1;
        out = lvl;
      end
      MODE_PASS: begin
        oe  = PASS_DRIVES;
        out = PASS_DRIVES ? pass_value(PIN_IDX, cs, sclk, din, lvl) : 1'b0;
      end
      default: begin
        oe  = 1'b0;
        out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/apio_regs.sv
module apio_regs
  import apio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  mode_q,
  output logic [NUM_PINS-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      level_q <= '0;
    end else if (wr) begin
      if (addr == ADDR_MODE)  mode_q  <= wdata;
      if (addr == ADDR_LEVEL) level_q <= wdata[NUM_PINS-1:0];
    end
  end
endmodule

// File: rtl/apio_wake_flag.sv
module apio_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_any,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_any) flag <= 1'b1;
    else if (sw_wr)   flag <= sw_val;
  end
endmodule

// File: rtl/apio_ctrl.sv
module apio_ctrl
  import apio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  input  logic                ser_cs,
  input  logic                ser_sclk,
  input  logic                ser_din,
  input  logic                ser_dout_core,
  output logic                ser_dout,
  output logic                osc_en
);
  logic [REG_W-1:0]    mode_q;
  logic [NUM_PINS-1:0] level_q;
  logic [NUM_PINS-1:0] sync_level;
  logic [NUM_PINS-1:0] wake_fall;
  logic [NUM_PINS-1:0] rd_level;
  logic                osc_wr;

  apio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .mode_q(mode_q), .level_q(level_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_mode_e m;
    assign m = mode_of(mode_q, i);

    apio_sync_edge #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in[i]),
      .arm(m == MODE_WAKE), .level(sync_level[i]), .fall(wake_fall[i])
    );

    apio_pin_drive #(.PIN_IDX(i)) u_drv (
      .mode(m), .lvl(level_q[i]), .cs(ser_cs), .sclk(ser_sclk),
      .din(ser_din), .oe(pin_oe[i]), .out(pin_out[i])
    );

    assign rd_level[i] = pin_oe[i] ? level_q[i] : sync_level[i];
  end

  assign osc_wr = reg_wr && (reg_addr == ADDR_OSC);

  apio_wake_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_any(|wake_fall),
    .sw_wr(osc_wr), .sw_val(reg_wdata[0]), .flag(osc_en)
  );

  assign ser_dout = ((mode_of(mode_q, 0) == MODE_PASS) && ser_cs) ? pin_in[0]
                                                                  : ser_dout_core;

  always_comb begin
    case (reg_addr)
      ADDR_MODE:  reg_rdata = mode_q;
      ADDR_LEVEL: reg_rdata = {{(REG_W-NUM_PINS){1'b0}}, rd_level};
      ADDR_OSC:   reg_rdata = {{(REG_W-1){1'b0}}, osc_en};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/apio_ctrl_chk.sv
module apio_ctrl_chk
  import apio_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-1:0]    mode_q,
  input logic [NUM_PINS-1:0] level_q,
  input logic [NUM_PINS-1:0] wake_fall,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                ser_cs,
  input logic                ser_sclk,
  input logic                ser_din,
  input logic                ser_dout_core,
  input logic                ser_dout,
  input logic                osc_en
);
  logic clr_wr, set_wr;
  assign clr_wr = reg_wr && reg_addr == ADDR_OSC && !reg_wdata[0];
  assign set_wr = reg_wr && reg_addr == ADDR_OSC &&  reg_wdata[0];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_a
    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i+1] == 1'b0) |-> (!pin_oe[i] && !pin_out[i])); // R3
    AST_GPOUT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b10) |-> (pin_oe[i] && pin_out[i] == level_q[i])); // R4
  end

  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_fall) |=> osc_en); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !clr_wr) |=> osc_en); // R6
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> ($past(|wake_fall) || $past(set_wr))); // R6
  AST_DOUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b11 && ser_cs) |-> (ser_dout == pin_in[0] && !pin_oe[0])); // R7
  AST_P2_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b11) |-> (pin_oe[1] && pin_out[1] == (ser_cs ? ser_din : level_q[1]))); // R8
  AST_P3_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11) |-> (pin_oe[2] && pin_out[2] == (ser_cs ? ser_sclk : level_q[2]))); // R9
  AST_P4_INV_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7:6] == 2'b11) |-> (pin_oe[3] && pin_out[3] == !ser_cs)); // R10
  AST_DOUT_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] != 2'b11 || !ser_cs) |-> (ser_dout == ser_dout_core)); // R7
endmodule

bind apio_ctrl apio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_q(mode_q), .level_q(level_q),
  .wake_fall(wake_fall), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
  .ser_cs(ser_cs), .ser_sclk(ser_sclk), .ser_din(ser_din),
  .ser_dout_core(ser_dout_core), .ser_dout(ser_dout), .osc_en(osc_en)
);

// File: tb/tb_apio_ctrl.sv
`timescale 1ns/1ps
module tb_apio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_in = 4'hF;
  logic [3:0] pin_oe, pin_out;
  logic ser_cs = 1'b0, ser_sclk = 1'b0, ser_din = 1'b0, ser_dout_core = 1'b0;
  logic ser_dout, osc_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .ser_cs(ser_cs), .ser_sclk(ser_sclk),
    .ser_din(ser_din), .ser_dout_core(ser_dout_core), .ser_dout(ser_dout),
    .osc_en(osc_en)
  );

  // {mode[7:0], level[3:0], cs, sclk, din, exp_oe[3:0], exp_out[3:0]}
  localparam logic [22:0] VEC [8] = '{
    {8'h00, 4'hF, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0},
    {8'hAA, 4'hA, 1'b0, 1'b0, 1'b0, 4'hF, 4'hA},
    {8'hFF, 4'h0, 1'b1, 1'b0, 1'b1, 4'hE, 4'h2},
    {8'hFF, 4'h6, 1'b0, 1'b1, 1'b0, 4'hE, 4'hE},
    {8'hFF, 4'h0, 1'b1, 1'b1, 1'b0, 4'hE, 4'h4},
    {8'h55, 4'hF, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0},
    {8'hB2, 4'h9, 1'b1, 1'b1, 1'b1, 4'hD, 4'hD},
    {8'h1C, 4'h0, 1'b1, 1'b1, 1'b1, 4'h2, 4'h2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_reg(2'd0, d); chk("R1 mode", d, 8'h00);
    rd_reg(2'd2, d); chk("R1 osc", d, 8'h00);
    chk("R1 oe", pin_oe, 4'h0);
    chk("R1 out", pin_out, 4'h0);
    wr_reg(2'd0, 8'hAA);
    rd_reg(2'd1, d); chk("R1 level", d, 8'h00);

    // Vector walk: R2 R3 R4 R8 R9 R10
    foreach (VEC[v]) begin
      wr_reg(2'd0, VEC[v][22:15]);
      wr_reg(2'd1, {4'h0, VEC[v][14:11]});
      ser_cs = VEC[v][10]; ser_sclk = VEC[v][9]; ser_din = VEC[v][8];
      rd_reg(2'd0, d);
      chk("R2 mode readback", d, VEC[v][22:15]);
      chk("R3 R4 R8 R9 R10 oe", pin_oe, VEC[v][7:4]);
      chk("R3 R4 R8 R9 R10 out", pin_out, VEC[v][3:0]);
    end

    // R3 input readback after synchronizer
    wr_reg(2'd0, 8'h00);
    pin_in = 4'b0101;
    wait_edges(3);
    rd_reg(2'd1, d); chk("R3 input level", d, 8'h05);

    // R4 output readback ignores pin input
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h0A);
    rd_reg(2'd1, d); chk("R4 stored level", d, 8'h0A);

    // R7 pin 1 pass-through to serial data out
    wr_reg(2'd0, 8'h03);
    ser_cs = 1'b1; ser_dout_core = 1'b0; pin_in[0] = 1'b1;
    #1 chk("R7 dout=pin hi", ser_dout, 1'b1);
    pin_in[0] = 1'b0;
    #1 chk("R7 dout=pin lo", ser_dout, 1'b0);
    chk("R7 oe", pin_oe[0], 1'b0);
    ser_cs = 1'b0; ser_dout_core = 1'b1;
    #1 chk("R7 dout=core cs low", ser_dout, 1'b1);
    wait_edges(3);
    rd_reg(2'd1, d); chk("R7 pin1 level", d[0], 1'b0);
    wr_reg(2'd0, 8'h00);
    ser_cs = 1'b1; ser_dout_core = 1'b0; pin_in[0] = 1'b1;
    #1 chk("R7 dout=core mode 00", ser_dout, 1'b0);

    // R5 fall in plain input mode does nothing
    pin_in = 4'hF;
    wait_edges(4);
    pin_in[0] = 1'b0;
    wait_edges(4);
    chk("R5 no wake in mode 00", osc_en, 1'b0);

    // R11 entering wake mode with pin already low
    wr_reg(2'd0, 8'h01);
    wait_edges(4);
    chk("R11 no wake on mode change", osc_en, 1'b0);

    // R5 real fall, exact latency
    pin_in[0] = 1'b1;
    wait_edges(4);
    pin_in[0] = 1'b0;
    wait_edges(2);
    chk("R5 not yet after 2 edges", osc_en, 1'b0);
    wait_edges(1);
    chk("R5 set after 3 edges", osc_en, 1'b1);

    // R6 sticky, readback, clear
    wait_edges(5);
    chk("R6 sticky", osc_en, 1'b1);
    rd_reg(2'd2, d); chk("R6 readback", d, 8'h01);
    wr_reg(2'd2, 8'h00);
    chk("R6 cleared", osc_en, 1'b0);
    wr_reg(2'd2, 8'h01);
    chk("R6 sw set", osc_en, 1'b1);
    wr_reg(2'd2, 8'h00);

    // R6 set wins over same-cycle clear
    pin_in[0] = 1'b1;
    wait_edges(4);
    pin_in[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R6 set beats clear", osc_en, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule